// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer

This block is one timer channel. A counter walks down from a programmed reload value toward zero, one step per tick. After zero it restarts from the reload value. The tick comes from one of two single-cycle strobes in the system clock domain: a fast bus-rate strobe or a slow external-reference strobe. A select input chooses which one.

Two match values and the zero point of the count can each raise an event. During one period, the larger match is reached first, then the smaller one, then zero. The interrupt output is a level, and each event inverts it. Software, or the logic around the block, reads the level and compares it with the last value it saw.

The reload value, both match values and the live count are loaded through simple write-enable/data pairs. Address decoding stays outside the block.

Top module: `dmatch_timer`

## Requirements
- R1: The active tick is `tick_bus` when `clk_sel` is 0 and `tick_ext` when `clk_sel` is 1. The strobe that is not selected has no effect on the count or on the interrupt.
- R2: In the first cycle in which `enable` is sampled high after being low, the count is loaded from the stored reload value. This load raises no event.
- R3: While enabled, with a nonzero reload value, each selected tick lowers the count by one. A tick that arrives while the count is 0 loads the count from the reload value that is stored at that moment.
- R4: When a tick moves the count onto a nonzero value equal to either match value, one event is raised. If both match values are equal, only one event is raised. A tick that moves the count onto a value other than a match, other than the zero case of R5, raises no event.
- R5: When a tick moves the count onto 0, an event is raised if `ovf_irq_en` is 1 or if either match value is 0. Otherwise no event is raised.
- R6: Every event inverts `irq_level`. Without an event, `irq_level` holds its value.
- R7: A count write while the block is enabled replaces the count and raises no event. The write takes priority over a tick in the same cycle. A count write while the block is disabled is ignored.
- R8: A reload write with a nonzero value, made while the stored reload is 0 and the block is enabled, also loads the count with that value. A reload write in any other case changes only the stored reload value, which is used at the next restart from zero.
- R9: While the stored reload value is 0, ticks leave the count unchanged and raise no events.
- R10: While `enable` is low, the count and `irq_level` hold their values.
- R11: Reset sets the reload value, both match values, the count and `irq_level` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the counter |
| clk_sel | input | 1 | Tick source select: 0 = bus strobe, 1 = external strobe |
| ovf_irq_en | input | 1 | Raise an event when the count reaches zero |
| tick_bus | input | 1 | Fast tick strobe, one cycle wide |
| tick_ext | input | 1 | Slow tick strobe, one cycle wide |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wd | input | 32 | Reload value to write |
| match1_we | input | 1 | Write strobe for the first match value |
| match1_wd | input | 32 | First match value to write |
| match2_we | input | 1 | Write strobe for the second match value |
| match2_wd | input | 32 | Second match value to write |
| count_we | input | 1 | Write strobe for the live count |
| count_wd | input | 32 | Count value to write |
| count | output | 32 | Live count |
| irq_level | output | 1 | Interrupt level, inverted by each event |

## Verification
Each result is registered at the rising edge that samples its stimulus. This covers a count step, a restart from zero, a load on enable, a count write or a reload-start write, and an inversion of the interrupt level. Each result can be seen one cycle after the stimulus is applied, with no further delay. The bench applies each stimulus at a falling edge. It compares `count` and `irq_level` at the next falling edge, half a cycle after the register update. Because the interrupt is an inverted level, every check compares against a level that the bench tracks, not against a pulse.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    parameter int unsigned DMT_CNT_W = 32;

    typedef enum logic {
        SRC_BUS = 1'b0,
        SRC_EXT = 1'b1
    } tick_src_e;

endpackage

// File: rtl/dmt_tick_mux.sv
module dmt_tick_mux
    import dmt_pkg::*;
(
    input  tick_src_e sel,
    input  logic      tick_bus,
    input  logic      tick_ext,
    output logic      tick
);

    always_comb begin
        tick = (sel == SRC_EXT) ? tick_ext : tick_bus;
    end

endmodule

// File: rtl/dmt_down_step.sv
module dmt_down_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] reload,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt = (cur == '0) ? reload : (cur - ONE);
    end

endmodule

// File: rtl/dmt_match_eval.sv
module dmt_match_eval #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] match1,
    input  logic [W-1:0] match2,
    input  logic         ovf_en,
    output logic         hit
);

    logic at_zero;
    logic on_match;
    logic zero_fire;

    always_comb begin
        at_zero   = (nxt == '0);
        on_match  = !at_zero && ((nxt == match1) || (nxt == match2));
        zero_fire = at_zero && (ovf_en || (match1 == '0) || (match2 == '0));
        hit       = on_match || zero_fire;
    end

endmodule

// File: rtl/dmatch_timer.sv
module dmatch_timer #(
    parameter int unsigned CNT_W = dmt_pkg::DMT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clk_sel,
    input  logic             ovf_irq_en,
    input  logic             tick_bus,
    input  logic             tick_ext,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wd,
    input  logic             match1_we,
    input  logic [CNT_W-1:0] match1_wd,
    input  logic             match2_we,
    input  logic [CNT_W-1:0] match2_wd,
    input  logic             count_we,
    input  logic [CNT_W-1:0] count_wd,
    output logic [CNT_W-1:0] count,
    output logic             irq_level
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] m1;
        logic [CNT_W-1:0] m2;
        logic             irq;
        logic             en_q;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic             tick;
    logic [CNT_W-1:0] step_nxt;
    logic             evt_hit;
    logic             restart_wr;

    dmt_tick_mux u_tick (
        .sel      (dmt_pkg::tick_src_e'(clk_sel)),
        .tick_bus (tick_bus),
        .tick_ext (tick_ext),
        .tick     (tick)
    );

    dmt_down_step #(.W(CNT_W)) u_step (
        .cur    (st_q.cnt),
        .reload (st_q.reload),
        .nxt    (step_nxt)
    );

    dmt_match_eval #(.W(CNT_W)) u_eval (
        .nxt    (step_nxt),
        .match1 (st_q.m1),
        .match2 (st_q.m2),
        .ovf_en (ovf_irq_en),
        .hit    (evt_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.en_q  = enable;
        restart_wr = reload_we && (st_q.reload == '0) && (reload_wd != '0);

        if (reload_we) st_d.reload = reload_wd;
        if (match1_we) st_d.m1     = match1_wd;
        if (match2_we) st_d.m2     = match2_wd;

        if (enable) begin
            if (!st_q.en_q) begin
                st_d.cnt = st_q.reload;
            end else if (count_we) begin
                st_d.cnt = count_wd;
            end else if (restart_wr) begin
                st_d.cnt = reload_wd;
            end else if (tick && (st_q.reload != '0)) begin
                st_d.cnt = step_nxt;
                if (evt_hit) st_d.irq = ~st_q.irq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count     = st_q.cnt;
    assign irq_level = st_q.irq;

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             clk_sel,
    input logic             tick_bus,
    input logic             tick_ext,
    input logic             count_we,
    input logic             reload_we,
    input logic [CNT_W-1:0] count,
    input logic             irq_level,
    input logic [CNT_W-1:0] reload_q,
    input logic             en_q
);

    logic sel_tick;
    assign sel_tick = clk_sel ? tick_ext : tick_bus;

    AST_UNSELECTED_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable && en_q && !count_we && !reload_we && !sel_tick)
        |-> $stable(count) && $stable(irq_level)); // R1

    AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable && !en_q) |-> (count == $past(reload_q)) && $stable(irq_level)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable && en_q && sel_tick && !count_we && !reload_we && (reload_q != '0))
        |-> count == (($past(count) == '0) ? $past(reload_q) : ($past(count) - 1'b1))); // R3

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != $past(irq_level))
        |-> $past(enable && en_q && sel_tick && !count_we && (reload_q != '0))); // R6

    AST_ZERO_RELOAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable && en_q && (reload_q == '0) && !count_we && !reload_we)
        |-> $stable(count) && $stable(irq_level)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> $stable(count) && $stable(irq_level)); // R10

endmodule

bind dmatch_timer dmt_checker #(.CNT_W(CNT_W)) u_dmt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .clk_sel   (clk_sel),
    .tick_bus  (tick_bus),
    .tick_ext  (tick_ext),
    .count_we  (count_we),
    .reload_we (reload_we),
    .count     (count),
    .irq_level (irq_level),
    .reload_q  (st_q.reload),
    .en_q      (st_q.en_q)
);

// File: tb/tb_dmatch_timer.sv
module tb_dmatch_timer;

    localparam int unsigned W = 32;
    localparam int unsigned NROW = 39;

    // write kinds: 0 none, 1 reload, 2 match1, 3 match2, 4 count
    typedef struct packed {
        logic         en;
        logic         sel;
        logic         ovf;
        logic         tb;
        logic         te;
        logic [2:0]   wk;
        logic [W-1:0] wd;
        logic [W-1:0] ec;
        logic         ei;
        logic [3:0]   req;
    } row_t;

    localparam row_t ROWS [NROW] = '{
        {5'b00000, 3'd1, 32'd5, 32'd0, 1'b0, 4'd10}, // R10 reload stored while off
        {5'b00000, 3'd2, 32'd3, 32'd0, 1'b0, 4'd10},
        {5'b00000, 3'd3, 32'd1, 32'd0, 1'b0, 4'd10},
        {5'b10000, 3'd0, 32'd0, 32'd5, 1'b0, 4'd2},  // R2 load on enable
        {5'b10010, 3'd0, 32'd0, 32'd4, 1'b0, 4'd3},  // R3 step
        {5'b10001, 3'd0, 32'd0, 32'd4, 1'b0, 4'd1},  // R1 ext ignored on sel 0
        {5'b10010, 3'd0, 32'd0, 32'd3, 1'b1, 4'd4},  // R4 larger match
        {5'b10010, 3'd0, 32'd0, 32'd2, 1'b1, 4'd6},  // R6 level held
        {5'b10010, 3'd0, 32'd0, 32'd1, 1'b0, 4'd4},  // R4 smaller match
        {5'b10010, 3'd0, 32'd0, 32'd0, 1'b0, 4'd5},  // R5 zero, no event
        {5'b10010, 3'd0, 32'd0, 32'd5, 1'b0, 4'd3},  // R3 restart
        {5'b11010, 3'd0, 32'd0, 32'd5, 1'b0, 4'd1},  // R1 bus ignored on sel 1
        {5'b11001, 3'd0, 32'd0, 32'd4, 1'b0, 4'd1},
        {5'b11101, 3'd0, 32'd0, 32'd3, 1'b1, 4'd4},
        {5'b11000, 3'd4, 32'd1, 32'd1, 1'b1, 4'd7},  // R7 count write
        {5'b11101, 3'd0, 32'd0, 32'd0, 1'b0, 4'd5},  // R5 zero with ovf enable
        {5'b01001, 3'd0, 32'd0, 32'd0, 1'b0, 4'd10}, // R10 tick while off
        {5'b01000, 3'd4, 32'd9, 32'd0, 1'b0, 4'd7},  // R7 write while off
        {5'b11000, 3'd0, 32'd0, 32'd5, 1'b0, 4'd2},
        {5'b11000, 3'd3, 32'd0, 32'd5, 1'b0, 4'd4},
        {5'b11001, 3'd0, 32'd0, 32'd4, 1'b0, 4'd3},
        {5'b11001, 3'd0, 32'd0, 32'd3, 1'b1, 4'd4},
        {5'b11001, 3'd0, 32'd0, 32'd2, 1'b1, 4'd6},
        {5'b11001, 3'd0, 32'd0, 32'd1, 1'b1, 4'd4},
        {5'b11001, 3'd0, 32'd0, 32'd0, 1'b0, 4'd5},  // R5 zero match value
        {5'b11000, 3'd1, 32'd0, 32'd0, 1'b0, 4'd9},
        {5'b11001, 3'd0, 32'd0, 32'd0, 1'b0, 4'd9},  // R9 frozen at zero reload
        {5'b11000, 3'd1, 32'd7, 32'd7, 1'b0, 4'd8},  // R8 restart from zero reload
        {5'b11001, 3'd0, 32'd0, 32'd6, 1'b0, 4'd3},
        {5'b11000, 3'd1, 32'd2, 32'd6, 1'b0, 4'd8},  // R8 reload only stored
        {5'b11000, 3'd2, 32'd4, 32'd6, 1'b0, 4'd4},
        {5'b11000, 3'd3, 32'd4, 32'd6, 1'b0, 4'd4},
        {5'b11001, 3'd0, 32'd0, 32'd5, 1'b0, 4'd3},
        {5'b11001, 3'd0, 32'd0, 32'd4, 1'b1, 4'd4},  // R4 equal matches, one event
        {5'b11001, 3'd0, 32'd0, 32'd3, 1'b1, 4'd4},
        {5'b11001, 3'd0, 32'd0, 32'd2, 1'b1, 4'd3},
        {5'b11001, 3'd0, 32'd0, 32'd1, 1'b1, 4'd3},
        {5'b11001, 3'd0, 32'd0, 32'd0, 1'b1, 4'd5},
        {5'b11001, 3'd0, 32'd0, 32'd2, 1'b1, 4'd8}   // R8 new reload at restart
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         enable, clk_sel, ovf_irq_en, tick_bus, tick_ext;
    logic         reload_we, match1_we, match2_we, count_we;
    logic [W-1:0] reload_wd, match1_wd, match2_wd, count_wd;
    logic [W-1:0] count;
    logic         irq_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dmatch_timer #(.CNT_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .clk_sel    (clk_sel),
        .ovf_irq_en (ovf_irq_en),
        .tick_bus   (tick_bus),
        .tick_ext   (tick_ext),
        .reload_we  (reload_we),
        .reload_wd  (reload_wd),
        .match1_we  (match1_we),
        .match1_wd  (match1_wd),
        .match2_we  (match2_we),
        .match2_wd  (match2_wd),
        .count_we   (count_we),
        .count_wd   (count_wd),
        .count      (count),
        .irq_level  (irq_level)
    );

    task automatic drive(input row_t r);
        enable     = r.en;
        clk_sel    = r.sel;
        ovf_irq_en = r.ovf;
        tick_bus   = r.tb;
        tick_ext   = r.te;
        reload_we  = (r.wk == 3'd1);
        match1_we  = (r.wk == 3'd2);
        match2_we  = (r.wk == 3'd3);
        count_we   = (r.wk == 3'd4);
        reload_wd  = r.wd;
        match1_wd  = r.wd;
        match2_wd  = r.wd;
        count_wd   = r.wd;
    endtask

    task automatic check(input string req, input logic [W-1:0] ec, input logic ei);
        n_checks++;
        if (count !== ec || irq_level !== ei) begin
            n_fail++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                     req, count, irq_level, ec, ei);
        end
    endtask

    task automatic step(input row_t r, input string req);
        drive(r);
        @(negedge clk);
        check(req, r.ec, r.ei);
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11", 32'd0, 1'b0); // reset state

        foreach (ROWS[i]) begin
            step(ROWS[i], $sformatf("R%0d row %0d", ROWS[i].req, i));
        end

        // R11: reset mid-run clears count, level, reload and matches
        drive('0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R11", 32'd0, 1'b0);
        step({5'b10000, 3'd0, 32'd0, 32'd0, 1'b0, 4'd11}, "R11 reload cleared");
        step({5'b10010, 3'd0, 32'd0, 32'd0, 1'b0, 4'd9},  "R9 tick at zero reload");
        step({5'b10000, 3'd1, 32'd3, 32'd3, 1'b0, 4'd8},  "R8 restart write");
        step({5'b10010, 3'd0, 32'd0, 32'd2, 1'b0, 4'd3},  "R3 step");
        step({5'b10010, 3'd0, 32'd0, 32'd1, 1'b0, 4'd4},  "R4 no match");
        step({5'b10010, 3'd0, 32'd0, 32'd0, 1'b1, 4'd11}, "R11 matches cleared");
        step({5'b10000, 3'd4, 32'd2, 32'd2, 1'b1, 4'd7},  "R7 write");
        step({5'b10010, 3'd4, 32'd2, 32'd2, 1'b1, 4'd7},  "R7 write beats tick");
        step({5'b00000, 3'd0, 32'd0, 32'd2, 1'b1, 4'd10}, "R10 off");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule